// File: doc/BRIEF.md
# Three-Tier Interrupt Priority Encoder

This block gathers level-sensitive interrupt requests from three source groups and turns them into a single encoded status word. The groups are a small critical group, a main group and a larger peripheral group. Each group has its own mask, and the word carries a separate index and valid flag for each group. Software reading the word checks the critical field first, then the main field, then the peripheral field. It services the first valid field it finds.

Any peripheral source can be promoted through a 2-bit boost setting. A source boosted to the high level shows up in the critical field as a reserved slot number. A source boosted to the medium level shows up in the main field as a reserved slot number. In both cases the identity of the pending peripheral source is in the peripheral field.

The masks, boost settings and a registered copy of the masked pending vectors are reached through a simple word-addressed register port. Writes take effect on the clock edge; reads are combinational. Requests and masks are sampled into a pending stage on every clock. The encoded word is formed from that stage.

Top module: `tier_irq_encoder`

## Requirements
- R1: After synchronous reset, every mask bit reads as 1 (peripheral mask at 0x00 reads all PER_N bits set, control at 0x10 reads 0xB, main mask at 0x14 reads all MAIN_N bits set), every boost field reads 0, and the encoded status and irq_out are 0.
- R2: A mask bit at 1 blocks its source. The pending registers at 0x28 (critical), 0x2C (main) and 0x30 (peripheral) return request AND NOT mask, as sampled at the previous clock edge. Critical mask bits sit in control bits 0, 1 and 3.
- R3: Critical field: bits 9:8 carry the lowest-numbered pending critical slot and bit 10 is its valid flag. Critical sources use slots 0, 1 and 3. Request input bit 2 has no effect.
- R4: Main field: bits 20:16 carry the lowest-numbered pending main slot and bit 21 is its valid flag. Request input bit 4 has no effect.
- R5: Peripheral field: bits 28:24 carry a pending peripheral index and bit 29 is its valid flag. Sources boosted high take precedence, then medium, then unboosted. The lowest index wins within a level.
- R6: Each peripheral source has a 2-bit boost field. Fields are packed 16 to a word: sources 0-15 at 0x04, 16-31 at 0x08 and 32-47 at 0x0C, with source s at bits 2(s mod 16)+1:2(s mod 16). Code 00 means no boost and 01 means medium. Codes 10 and 11 mean high. A pending high source fills critical slot 2, and a pending medium source fills main slot 4.
- R7: A field's valid flag and index are both 0 when its group, including the boosted slot, has nothing pending.
- R8: The following read 0 and ignore writes: offsets 0x18, 0x1C, 0x20, 0x34 and 0x38, any other unlisted offset, and any address that is not a multiple of four. Writes to the status offsets 0x24 to 0x30 are ignored.
- R9: irq_out is 1 exactly when at least one of the three valid flags is 1. Reading 0x24 returns the encoded word.
- R10: A request change becomes visible in the encoded word after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_req | input | 4 | Critical requests on slots 0, 1, 3 (bit 2 unused) |
| main_req | input | MAIN_N | Main requests (bit 4 unused) |
| per_req | input | PER_N | Peripheral requests |
| reg_addr | input | ADDR_W | Byte address of register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| enc_status | output | 32 | Encoded status word |
| irq_out | output | 1 | Any field valid |

## Verification
All 16 critical request patterns are swept, including the unused slot. This separates lowest-slot selection from a wrong order and catches a leak through slot 2. Every pair of main requests is applied, which tells lowest-index selection apart from highest-index selection and also exercises the reserved slot 4. Pseudo-random peripheral requests under pseudo-random boost settings separate the three boost levels and the reserved critical and main slots. Random masks compared against the pending registers show mask polarity, and a single-edge probe pins down the one-cycle latency.

// File: rtl/tier_irq_pkg.sv
package tier_irq_pkg;

    localparam int CRIT_SLOTS      = 4;
    localparam int CRIT_BOOST_SLOT = 2;
    localparam int MAIN_BOOST_SLOT = 4;
    localparam int FIELDS_PER_WORD = 16;
    localparam logic [3:0] CRIT_LIVE = 4'b1011;

    // word indices (byte offset / 4)
    localparam logic [5:0] W_PMASK   = 6'h00;
    localparam logic [5:0] W_PBOOST0 = 6'h01;
    localparam logic [5:0] W_PBOOST1 = 6'h02;
    localparam logic [5:0] W_PBOOST2 = 6'h03;
    localparam logic [5:0] W_CTRL    = 6'h04;
    localparam logic [5:0] W_MMASK   = 6'h05;
    localparam logic [5:0] W_ENC     = 6'h09;
    localparam logic [5:0] W_CPEND   = 6'h0A;
    localparam logic [5:0] W_MPEND   = 6'h0B;
    localparam logic [5:0] W_PPEND   = 6'h0C;

    typedef enum logic [1:0] {
        BOOST_NONE = 2'b00,
        BOOST_MED  = 2'b01,
        BOOST_HIGH = 2'b10,
        BOOST_TOP  = 2'b11
    } boost_e;

    typedef struct packed {
        logic [1:0] cidx;
        logic       cv;
        logic [4:0] midx;
        logic       mv;
        logic [4:0] pidx;
        logic       pv;
    } enc_t;

    function automatic logic [31:0] pack_enc(enc_t e);
        logic [31:0] w;
        w        = '0;
        w[9:8]   = e.cidx;
        w[10]    = e.cv;
        w[20:16] = e.midx;
        w[21]    = e.mv;
        w[28:24] = e.pidx;
        w[29]    = e.pv;
        return w;
    endfunction

endpackage

// File: rtl/tier_irq_pick.sv
module tier_irq_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          hit
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        hit = |vec;
    end
endmodule

// File: rtl/tier_irq_regs.sv
module tier_irq_regs
    import tier_irq_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        crit_pend,
    input  logic [MAIN_N-1:0] main_pend,
    input  logic [PER_N-1:0]  per_pend,
    input  logic [31:0]       enc_word,
    output logic [3:0]        cmask,
    output logic [MAIN_N-1:0] mmask,
    output logic [PER_N-1:0]  pmask,
    output logic [1:0]        boost [PER_N],
    output logic [31:0]       rdata
);
    localparam int BOOST_WORDS = 3;

    logic [5:0] widx;
    logic       aligned;
    logic       wr_ok;

    assign widx    = 6'(addr >> 2);
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ok   = wr && aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmask <= CRIT_LIVE;
            mmask <= '1;
            pmask <= '1;
        end else if (wr_ok) begin
            if (widx == W_CTRL)  cmask <= wdata[3:0] & CRIT_LIVE;
            if (widx == W_MMASK) mmask <= wdata[MAIN_N-1:0];
            if (widx == W_PMASK) pmask <= wdata[PER_N-1:0];
        end
    end

    for (genvar s = 0; s < PER_N; s++) begin : g_boost
        localparam logic [5:0] SW = W_PBOOST0 + 6'(s / FIELDS_PER_WORD);
        localparam int         SB = 2 * (s % FIELDS_PER_WORD);
        always_ff @(posedge clk) begin
            if (rst)                      boost[s] <= BOOST_NONE;
            else if (wr_ok && widx == SW) boost[s] <= wdata[SB+:2];
        end
    end

    logic [31:0] bword [BOOST_WORDS];
    always_comb begin
        for (int w = 0; w < BOOST_WORDS; w++) begin
            bword[w] = '0;
            for (int f = 0; f < FIELDS_PER_WORD; f++) begin
                if (w * FIELDS_PER_WORD + f < PER_N)
                    bword[w][2*f+:2] = boost[w*FIELDS_PER_WORD+f];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (widx)
                W_PMASK:   rdata = 32'(pmask);
                W_PBOOST0: rdata = bword[0];
                W_PBOOST1: rdata = bword[1];
                W_PBOOST2: rdata = bword[2];
                W_CTRL:    rdata = 32'(cmask);
                W_MMASK:   rdata = 32'(mmask);
                W_ENC:     rdata = enc_word;
                W_CPEND:   rdata = 32'(crit_pend);
                W_MPEND:   rdata = 32'(main_pend);
                W_PPEND:   rdata = 32'(per_pend);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tier_irq_encoder.sv
module tier_irq_encoder
    import tier_irq_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        crit_req,
    input  logic [MAIN_N-1:0] main_req,
    input  logic [PER_N-1:0]  per_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       enc_status,
    output logic              irq_out
);
    localparam logic [MAIN_N-1:0] MAIN_LIVE = ~(MAIN_N'(1) << MAIN_BOOST_SLOT);

    logic [3:0]        cmask;
    logic [MAIN_N-1:0] mmask;
    logic [PER_N-1:0]  pmask;
    logic [1:0]        boost [PER_N];

    logic [3:0]        crit_pend_q;
    logic [MAIN_N-1:0] main_pend_q;
    logic [PER_N-1:0]  per_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crit_pend_q <= '0;
            main_pend_q <= '0;
            per_pend_q  <= '0;
        end else begin
            crit_pend_q <= crit_req & ~cmask & CRIT_LIVE;
            main_pend_q <= main_req & ~mmask & MAIN_LIVE;
            per_pend_q  <= per_req & ~pmask;
        end
    end

    // split pending peripherals by boost level
    logic [PER_N-1:0] per_hi, per_med, per_lo;
    always_comb begin
        for (int s = 0; s < PER_N; s++) begin
            per_hi[s]  = per_pend_q[s] & boost[s][1];
            per_med[s] = per_pend_q[s] & (boost[s] == BOOST_MED);
            per_lo[s]  = per_pend_q[s] & (boost[s] == BOOST_NONE);
        end
    end

    logic [3:0]        crit_vec;
    logic [MAIN_N-1:0] main_vec;
    always_comb begin
        crit_vec = crit_pend_q;
        crit_vec[CRIT_BOOST_SLOT] = |per_hi;
        main_vec = main_pend_q;
        main_vec[MAIN_BOOST_SLOT] = |per_med;
    end

    logic [1:0] c_idx;
    logic       c_hit;
    logic [4:0] m_idx;
    logic       m_hit;
    logic [4:0] p_idx [3];
    logic       p_hit [3];
    logic [PER_N-1:0] tier_vec [3];

    assign tier_vec[0] = per_hi;
    assign tier_vec[1] = per_med;
    assign tier_vec[2] = per_lo;

    tier_irq_pick #(.W(CRIT_SLOTS), .IW(2)) u_pick_crit (
        .vec(crit_vec), .idx(c_idx), .hit(c_hit)
    );
    tier_irq_pick #(.W(MAIN_N), .IW(5)) u_pick_main (
        .vec(main_vec), .idx(m_idx), .hit(m_hit)
    );
    for (genvar t = 0; t < 3; t++) begin : g_tier
        tier_irq_pick #(.W(PER_N), .IW(5)) u_pick_per (
            .vec(tier_vec[t]), .idx(p_idx[t]), .hit(p_hit[t])
        );
    end

    enc_t enc;
    always_comb begin
        enc.cidx = c_idx;
        enc.cv   = c_hit;
        enc.midx = m_idx;
        enc.mv   = m_hit;
        enc.pv   = p_hit[0] | p_hit[1] | p_hit[2];
        if (p_hit[0])      enc.pidx = p_idx[0];
        else if (p_hit[1]) enc.pidx = p_idx[1];
        else               enc.pidx = p_idx[2];
    end

    assign enc_status = pack_enc(enc);
    assign irq_out    = enc.cv | enc.mv | enc.pv;

    tier_irq_regs #(.MAIN_N(MAIN_N), .PER_N(PER_N), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .crit_pend(crit_pend_q),
        .main_pend(main_pend_q),
        .per_pend (per_pend_q),
        .enc_word (enc_status),
        .cmask    (cmask),
        .mmask    (mmask),
        .pmask    (pmask),
        .boost    (boost),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/tier_irq_checker.sv
module tier_irq_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  crit_req,
    input logic [3:0]  cmask,
    input logic [31:0] enc
);
    AST_CRIT_BOOST_HAS_PER: assert property (@(posedge clk) disable iff (rst)
        (enc[10] && enc[9:8] == 2'd2) |-> enc[29]); // R6

    AST_MAIN_BOOST_HAS_PER: assert property (@(posedge clk) disable iff (rst)
        (enc[21] && enc[20:16] == 5'd4) |-> enc[29]); // R6

    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!enc[10] |-> enc[9:8] == 2'd0) and (!enc[21] |-> enc[20:16] == 5'd0)
        and (!enc[29] |-> enc[28:24] == 5'd0)); // R7

    AST_CRIT_SLOT0_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(crit_req[0]) && !$past(cmask[0]))
        |-> (enc[10] && enc[9:8] == 2'd0)); // R3

    AST_CRIT_UNMASKED_ONLY: assert property (@(posedge clk) disable iff (rst)
        (enc[10] && enc[9:8] != 2'd2)
        |-> ((($past(crit_req & ~cmask)) >> enc[9:8]) & 4'd1) == 4'd1); // R2
endmodule

bind tier_irq_encoder tier_irq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .crit_req(crit_req),
    .cmask   (cmask),
    .enc     (enc_status)
);

// File: tb/tier_irq_encoder_test.sv
module tier_irq_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAIN_N = 17;
    localparam int PER_N  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        crit_req = '0;
    logic [MAIN_N-1:0] main_req = '0;
    logic [PER_N-1:0]  per_req = '0;
    logic [7:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [31:0]       enc_status;
    logic              irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [3:0]          sh_cm;
    logic [MAIN_N-1:0]   sh_mm;
    logic [PER_N-1:0]    sh_pm;
    logic [2*PER_N-1:0]  sh_bst;
    logic [31:0]         rng = 32'h1357_9BDF;

    always #(CLK_PERIOD/2) clk = ~clk;

    tier_irq_encoder #(.MAIN_N(MAIN_N), .PER_N(PER_N), .ADDR_W(8)) uut (
        .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req),
        .per_req(per_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .enc_status(enc_status), .irq_out(irq_out)
    );

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] model();
        logic [3:0]        cp;
        logic [MAIN_N-1:0] mp;
        logic [PER_N-1:0]  pp;
        logic [31:0]       w;
        int lvl_best;
        int p_best;
        int c_best;
        int m_best;
        bit any_hi;
        bit any_med;
        cp = crit_req & ~sh_cm;
        cp[2] = 1'b0;
        mp = main_req & ~sh_mm;
        mp[4] = 1'b0;
        pp = per_req & ~sh_pm;
        any_hi = 0; any_med = 0; p_best = -1; lvl_best = 9;
        for (int s = 0; s < PER_N; s++) begin
            if (pp[s]) begin
                int lv;
                lv = (sh_bst[2*s+1]) ? 0 : (sh_bst[2*s] ? 1 : 2);
                if (lv == 0) any_hi = 1;
                if (lv == 1) any_med = 1;
                if (lv < lvl_best) begin lvl_best = lv; p_best = s; end
            end
        end
        if (any_hi) cp[2] = 1'b1;
        if (any_med) mp[4] = 1'b1;
        c_best = -1;
        for (int i = 3; i >= 0; i--) if (cp[i]) c_best = i;
        m_best = -1;
        for (int i = MAIN_N - 1; i >= 0; i--) if (mp[i]) m_best = i;
        w = '0;
        if (c_best >= 0) begin w[9:8] = 2'(c_best); w[10] = 1'b1; end
        if (m_best >= 0) begin w[20:16] = 5'(m_best); w[21] = 1'b1; end
        if (p_best >= 0) begin w[28:24] = 5'(p_best); w[29] = 1'b1; end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic load_cfg();
        wr(8'h10, 32'(sh_cm));
        wr(8'h14, 32'(sh_mm));
        wr(8'h00, 32'(sh_pm));
        wr(8'h04, sh_bst[31:0]);
        wr(8'h08, {16'h0, sh_bst[47:32]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main_seq
        logic [31:0] d;
        logic [31:0] e;
        sh_cm = 4'b1011; sh_mm = '1; sh_pm = '1; sh_bst = '0;
        crit_req = '1; main_req = '1; per_req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 pmask", d, 32'h00FF_FFFF);
        rd(8'h10, d); chk("R1 ctrl", d, 32'h0000_000B);
        rd(8'h14, d); chk("R1 mmask", d, 32'h0001_FFFF);
        rd(8'h04, d); chk("R1 boost0", d, 32'h0);
        rd(8'h08, d); chk("R1 boost1", d, 32'h0);
        step();
        chk("R1 enc masked", enc_status, 32'h0);
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        rd(8'h2C, d); chk("R2 masked main pend", d, 32'h0);

        // unmask everything
        crit_req = '0; main_req = '0; per_req = '0;
        sh_cm = '0; sh_mm = '0; sh_pm = '0;
        load_cfg();
        step();
        chk("R7 idle enc", enc_status, 32'h0);

        // R3 full critical sweep
        for (int c = 0; c < 16; c++) begin
            crit_req = 4'(c);
            step();
            chk("R3 crit sweep", enc_status, model());
        end
        crit_req = 4'b0100;
        step();
        chk("R3 slot2 ignored", enc_status, 32'h0);
        crit_req = '0;

        // R4 every pair of main requests
        for (int i = 0; i < MAIN_N; i++) begin
            for (int j = 0; j < MAIN_N; j++) begin
                main_req = (MAIN_N'(1) << i) | (MAIN_N'(1) << j);
                step();
                chk("R4 main pair", enc_status, model());
            end
        end
        main_req = MAIN_N'(1) << 4;
        step();
        chk("R4 slot4 ignored", enc_status, 32'h0);
        main_req = '0;

        // R6 directed boosts
        sh_bst = '0;
        sh_bst[2*5+:2] = 2'b10;
        sh_bst[2*7+:2] = 2'b01;
        load_cfg();
        per_req = PER_N'(1) << 5;
        step();
        chk("R6 high boost", enc_status, (32'h1 << 29) | (32'd5 << 24) | 32'h0000_0600);
        per_req = PER_N'(1) << 7;
        step();
        chk("R6 medium boost", enc_status, (32'h1 << 29) | (32'd7 << 24) | (32'h1 << 21) | (32'd4 << 16));
        per_req = (PER_N'(1) << 7) | (PER_N'(1) << 9) | (PER_N'(1) << 5);
        step();
        chk("R5 high tier first", enc_status, model());
        rd(8'h04, d); chk("R6 boost readback", d, sh_bst[31:0]);

        // R5/R6 random peripheral and boost patterns
        for (int k = 0; k < 200; k++) begin
            rng = next_rng(rng);
            if (k % 8 == 0) begin
                sh_bst = {rng[15:0], next_rng(rng)};
                load_cfg();
            end
            per_req = PER_N'(rng);
            crit_req = (k % 3 == 0) ? 4'(rng >> 28) : 4'h0;
            main_req = (k % 4 == 0) ? MAIN_N'(rng >> 11) : '0;
            step();
            e = model();
            chk("R5 periph random", enc_status, e);
            chk("R9 irq_out", 32'(irq_out), 32'(e[10] | e[21] | e[29]));
        end

        // R2 random masks
        for (int k = 0; k < 100; k++) begin
            rng = next_rng(rng);
            sh_cm = 4'(rng) & 4'b1011;
            sh_mm = MAIN_N'(rng >> 4);
            sh_pm = PER_N'(next_rng(rng));
            rng = next_rng(next_rng(rng));
            crit_req = 4'(rng >> 3);
            main_req = MAIN_N'(rng >> 7);
            per_req = PER_N'(rng ^ 32'hA5A5_5A5A);
            load_cfg();
            step();
            chk("R2 masked enc", enc_status, model());
            rd(8'h28, d); chk("R2 crit pend", d, 32'(crit_req & ~sh_cm & 4'b1011));
            rd(8'h2C, d); chk("R2 main pend", d, 32'((main_req & ~sh_mm) & ~(MAIN_N'(1) << 4)));
            rd(8'h30, d); chk("R2 per pend", d, 32'(per_req & ~sh_pm));
            rd(8'h24, d); chk("R9 enc read", d, enc_status);
        end

        // R8 reserved and read-only offsets
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h11, 32'h0000_0000);
        rd(8'h18, d); chk("R8 0x18", d, 32'h0);
        rd(8'h1C, d); chk("R8 0x1C", d, 32'h0);
        rd(8'h20, d); chk("R8 0x20", d, 32'h0);
        rd(8'h34, d); chk("R8 0x34", d, 32'h0);
        rd(8'h38, d); chk("R8 0x38", d, 32'h0);
        rd(8'h12, d); chk("R8 unaligned", d, 32'h0);
        rd(8'h10, d); chk("R8 ctrl kept", d, 32'(sh_cm));
        rd(8'h14, d); chk("R8 mmask kept", d, 32'(sh_mm));
        rd(8'h00, d); chk("R8 pmask kept", d, 32'(sh_pm));
        rd(8'h24, d); chk("R8 enc not writable", d, model());

        // R10 one-edge latency
        sh_cm = '0; sh_mm = '0; sh_pm = '0; sh_bst = '0;
        load_cfg();
        crit_req = '0; main_req = '0; per_req = '0;
        step();
        @(negedge clk);
        main_req = MAIN_N'(1) << 3;
        #1;
        chk("R10 before edge", enc_status, 32'h0);
        @(posedge clk);
        #1;
        chk("R10 after edge", enc_status, (32'h1 << 21) | (32'd3 << 16));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule